// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block is the address engine of one DMA channel. Software loads a line length, a line pitch, a line count and a six-bit control word, then writes a 32-bit start word address (a byte address shifted right by two). That write is the last step of programming and starts the transfer. After that, a data mover accepts one word per asserted `xfer_ack`, and the engine steps `cur_addr` through the region. `cur_addr` always shows the current transfer position.

In normal mode the engine walks `cfg_len` words from each line base, then moves the base on by `cfg_pitch` words. `cfg_lines` is programmed as the number of lines minus one. After the last word of the last line it raises one completion pulse and goes idle.

A line length of zero selects ring mode. The engine then cycles over `cfg_pitch * (cfg_lines + 1)` words starting at the start address. It pulses once when the first half of that ring is consumed and once when the ring wraps back to the start. Ring stepping happens only while `loop_en` is high, so dropping `loop_en` pauses the ring without losing its position. A `stop` strobe ends any transfer quietly.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `cur_addr` and all interrupt pulses are 0. A cycle with `addr_wr` high captures `cfg_len`, `cfg_pitch`, `cfg_lines`, `cfg_ctrl` and `addr_wdata`. After that edge, `busy` is 1 and `cur_addr` equals `addr_wdata`.
- R2: The control word captured at start is decoded as follows: bits [3:0] give `chan_id`, bit 4 gives `burst4` (four-word burst), and bit 5 gives `dir_m2d` (1 = memory to device, 0 = device to memory). Later changes on `cfg_ctrl` have no effect until the next start.
- R3: `cur_addr` changes only on a clock edge where `xfer_ack` is high while `busy` is 1. Without the handshake, or while idle, it holds its value.
- R4: In normal mode (`cfg_len` not zero), each accepted word advances the address by one within a line. After `cfg_len` words, the next address is the previous line base plus `cfg_pitch`.
- R5: After the last word of line number `cfg_lines` is accepted, `irq_done` is high for exactly one cycle and `busy` falls in the same cycle. `cur_addr` then equals the last line base plus `cfg_len`.
- R6: With `cfg_len` equal to 0, the address is the start plus an offset that counts accepted words. The offset returns to zero after `cfg_pitch*(cfg_lines+1)` words, and the engine never goes idle by itself.
- R7: In ring mode, `irq_half` pulses when the offset reaches half the ring (ring size shifted right by one). `irq_lap` pulses when the address wraps to the start.
- R8: While `loop_en` is 0, handshakes are ignored in ring mode and the address holds. When `loop_en` returns to 1, the ring resumes from the held address. `loop_en` has no effect in normal mode.
- R9: `stop` makes the engine idle at the next edge with no interrupt pulse, and `cur_addr` is kept. `stop` takes priority over `xfer_ack`, and `addr_wr` takes priority over `stop`.
- R10: Interrupt pulses last one cycle, and at most one of `irq_done`, `irq_half` and `irq_lap` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | LEN_W | Words per line; 0 selects ring mode |
| cfg_pitch | input | PITCH_W | Line-to-line distance in words |
| cfg_lines | input | CNT_W | Number of lines minus one |
| cfg_ctrl | input | 6 | Channel id, burst and direction bits |
| addr_wr | input | 1 | Start strobe; captures configuration and start address |
| addr_wdata | input | 32 | Start word address |
| loop_en | input | 1 | Allows ring-mode stepping |
| stop | input | 1 | Abort strobe |
| xfer_ack | input | 1 | Data mover accepted one word |
| cur_addr | output | 32 | Current word address |
| busy | output | 1 | Transfer in progress |
| chan_id | output | 4 | Captured channel number |
| burst4 | output | 1 | Four-word burst mode |
| dir_m2d | output | 1 | 1 = memory to device |
| irq_done | output | 1 | Normal transfer completed |
| irq_half | output | 1 | Ring first half consumed |
| irq_lap | output | 1 | Ring wrapped to start |

## Verification
A table drives normal-mode walks with four shapes. Pitch equal to length checks that a contiguous block runs as one straight count. Pitch larger than length checks the line jump. Single-word lines check that line end and word step are told apart. A single line checks that completion comes without any line jump. Handshakes arrive back to back or spaced by idle cycles, which separates address motion that follows the handshake from motion that follows the clock. Directed tests run a ring past its wrap to place the half and lap pulses, pause and resume it with `loop_en`, and stop a transfer in the middle. They also check the priorities between `stop`, `xfer_ack` and `addr_wr`.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int WORD_AW = 32;
  localparam int CTRL_W  = 6;

  // bit 5 direction, bit 4 burst, bits 3:0 channel
  typedef struct packed {
    logic       dir_m2d;
    logic       burst4;
    logic [3:0] chan;
  } chan_ctrl_t;

  function automatic chan_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] raw);
    return chan_ctrl_t'(raw);
  endfunction

  // ring size in words: pitch times number of lines
  function automatic logic [WORD_AW-1:0] ring_words(input logic [WORD_AW-1:0] pitch,
                                                    input logic [WORD_AW-1:0] lines_m1);
    return pitch * (lines_m1 + 1);
  endfunction

  function automatic logic [WORD_AW-1:0] ring_half(input logic [WORD_AW-1:0] total);
    return total >> 1;
  endfunction
endpackage

// File: rtl/dma2d_line_walker.sv
module dma2d_line_walker
  import dma2d_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_AW-1:0] start_addr,
  input  logic [LEN_W-1:0]   len,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [CNT_W-1:0]   lines_m1,
  input  logic               step,
  output logic [WORD_AW-1:0] addr,
  output logic               last_word
);
  logic [LEN_W-1:0]   col_q;
  logic [CNT_W-1:0]   row_q;
  logic [WORD_AW-1:0] base_q;
  logic [WORD_AW-1:0] addr_q;
  logic               line_end;

  assign line_end  = (col_q == LEN_W'(len - 1'b1));
  assign last_word = line_end && (row_q == lines_m1);
  assign addr      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      base_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      col_q  <= '0;
      row_q  <= '0;
      base_q <= start_addr;
      addr_q <= start_addr;
    end else if (step) begin
      if (last_word) begin
        addr_q <= addr_q + 1'b1;
      end else if (line_end) begin
        col_q  <= '0;
        row_q  <= row_q + 1'b1;
        base_q <= base_q + WORD_AW'(pitch);
        addr_q <= base_q + WORD_AW'(pitch);
      end else begin
        col_q  <= col_q + 1'b1;
        addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma2d_ring_walker.sv
module dma2d_ring_walker
  import dma2d_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_AW-1:0] start_addr,
  input  logic [WORD_AW-1:0] total,
  input  logic               step,
  output logic [WORD_AW-1:0] addr,
  output logic               hit_half,
  output logic               hit_lap
);
  logic [WORD_AW-1:0] base_q;
  logic [WORD_AW-1:0] off_q;
  logic [WORD_AW-1:0] off_nx;

  assign off_nx   = off_q + 1'b1;
  assign hit_half = step && (off_nx == ring_half(total));
  assign hit_lap  = step && (off_nx == total);
  assign addr     = base_q + off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      base_q <= start_addr;
      off_q  <= '0;
    end else if (step) begin
      off_q <= hit_lap ? '0 : off_nx;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [PITCH_W-1:0] cfg_pitch,
  input  logic [CNT_W-1:0]   cfg_lines,
  input  logic [5:0]         cfg_ctrl,
  input  logic               addr_wr,
  input  logic [31:0]        addr_wdata,
  input  logic               loop_en,
  input  logic               stop,
  input  logic               xfer_ack,
  output logic [31:0]        cur_addr,
  output logic               busy,
  output logic [3:0]         chan_id,
  output logic               burst4,
  output logic               dir_m2d,
  output logic               irq_done,
  output logic               irq_half,
  output logic               irq_lap
);
  logic [LEN_W-1:0]   len_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [CNT_W-1:0]   lines_q;
  chan_ctrl_t         ctrl_q;
  logic               busy_q;
  logic               loop_mode;
  logic               done_q, half_q, lap_q;

  // named internal events
  logic               accept;
  logic               step_line;
  logic               step_ring;
  logic               line_last;
  logic               ring_half_ev;
  logic               ring_lap_ev;
  logic [WORD_AW-1:0] line_addr;
  logic [WORD_AW-1:0] ring_addr;
  logic [WORD_AW-1:0] ring_total;

  assign accept     = busy_q && xfer_ack && !stop && !addr_wr;
  assign step_line  = accept && !loop_mode;
  assign step_ring  = accept && loop_mode && loop_en;
  assign ring_total = ring_words(WORD_AW'(pitch_q), WORD_AW'(lines_q));

  dma2d_line_walker #(
    .LEN_W  (LEN_W),
    .PITCH_W(PITCH_W),
    .CNT_W  (CNT_W)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_wr),
    .start_addr(addr_wdata),
    .len       (len_q),
    .pitch     (pitch_q),
    .lines_m1  (lines_q),
    .step      (step_line),
    .addr      (line_addr),
    .last_word (line_last)
  );

  dma2d_ring_walker u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_wr),
    .start_addr(addr_wdata),
    .total     (ring_total),
    .step      (step_ring),
    .addr      (ring_addr),
    .hit_half  (ring_half_ev),
    .hit_lap   (ring_lap_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      pitch_q   <= '0;
      lines_q   <= '0;
      ctrl_q    <= '0;
      busy_q    <= 1'b0;
      loop_mode <= 1'b0;
      done_q    <= 1'b0;
      half_q    <= 1'b0;
      lap_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      half_q <= ring_half_ev;
      lap_q  <= ring_lap_ev;
      if (addr_wr) begin
        len_q     <= cfg_len;
        pitch_q   <= cfg_pitch;
        lines_q   <= cfg_lines;
        ctrl_q    <= decode_ctrl(cfg_ctrl);
        busy_q    <= 1'b1;
        loop_mode <= (cfg_len == '0);
      end else if (stop) begin
        busy_q <= 1'b0;
      end else if (step_line && line_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign cur_addr = loop_mode ? ring_addr : line_addr;
  assign busy     = busy_q;
  assign chan_id  = ctrl_q.chan;
  assign burst4   = ctrl_q.burst4;
  assign dir_m2d  = ctrl_q.dir_m2d;
  assign irq_done = done_q;
  assign irq_half = half_q;
  assign irq_lap  = lap_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_wr,
  input logic [31:0] addr_wdata,
  input logic        stop,
  input logic        xfer_ack,
  input logic        loop_en,
  input logic        loop_mode,
  input logic        busy,
  input logic [31:0] cur_addr,
  input logic        irq_done,
  input logic        irq_half,
  input logic        irq_lap
);
  p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (busy && cur_addr == $past(addr_wdata)));

  p_hold_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_wr && (!xfer_ack || !busy)) |=> $stable(cur_addr));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (!busy && $past(busy)));

  p_ring_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && loop_mode && !loop_en && !addr_wr) |=> $stable(cur_addr));

  p_ring_no_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && loop_mode && !stop && !addr_wr) |=> busy);

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !addr_wr) |=> (!busy && !irq_done && !irq_half && !irq_lap
                            && $stable(cur_addr)));

  p_one_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_done, irq_half, irq_lap}));

  p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_wr   (addr_wr),
  .addr_wdata(addr_wdata),
  .stop      (stop),
  .xfer_ack  (xfer_ack),
  .loop_en   (loop_en),
  .loop_mode (loop_mode),
  .busy      (busy),
  .cur_addr  (cur_addr),
  .irq_done  (irq_done),
  .irq_half  (irq_half),
  .irq_lap   (irq_lap)
);

// File: tb/dma2d_addr_gen_tb.sv
`timescale 1ns/100ps
module dma2d_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_len = '0, cfg_pitch = '0, cfg_lines = '0;
  logic [5:0]  cfg_ctrl = '0;
  logic        addr_wr = 1'b0, loop_en = 1'b0, stop = 1'b0, xfer_ack = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic [31:0] cur_addr;
  logic        busy, burst4, dir_m2d, irq_done, irq_half, irq_lap;
  logic [3:0]  chan_id;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_pitch(cfg_pitch),
    .cfg_lines(cfg_lines), .cfg_ctrl(cfg_ctrl), .addr_wr(addr_wr),
    .addr_wdata(addr_wdata), .loop_en(loop_en), .stop(stop), .xfer_ack(xfer_ack),
    .cur_addr(cur_addr), .busy(busy), .chan_id(chan_id), .burst4(burst4),
    .dir_m2d(dir_m2d), .irq_done(irq_done), .irq_half(irq_half), .irq_lap(irq_lap)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [7:0]  len;
    logic [7:0]  pitch;
    logic [7:0]  lines;
    logic [5:0]  ctrl;
    logic [1:0]  gap;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h0000_0100, 8'd4, 8'd4,  8'd2, 6'h23, 2'd0},
    '{32'h0000_2000, 8'd3, 8'd8,  8'd1, 6'h15, 2'd1},
    '{32'h0000_FFF0, 8'd1, 8'd2,  8'd3, 6'h0A, 2'd2},
    '{32'h0000_0040, 8'd5, 8'd5,  8'd0, 6'h3F, 2'd0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] exp;
    bit last;
    cfg_len = 16'(v.len); cfg_pitch = 16'(v.pitch); cfg_lines = 16'(v.lines);
    cfg_ctrl = v.ctrl; addr_wdata = v.start; addr_wr = 1'b1;
    tick();
    addr_wr = 1'b0;
    cfg_ctrl = ~v.ctrl; cfg_len = 16'd7; cfg_pitch = 16'd1; cfg_lines = 16'd0;
    chk("R1 busy after start", 32'(busy), 32'd1);
    chk("R1 start address", cur_addr, v.start);
    chk("R2 chan_id", 32'(chan_id), 32'(v.ctrl[3:0]));
    chk("R2 burst4", 32'(burst4), 32'(v.ctrl[4]));
    chk("R2 dir_m2d", 32'(dir_m2d), 32'(v.ctrl[5]));
    for (int l = 0; l <= int'(v.lines); l++) begin
      for (int c = 0; c < int'(v.len); c++) begin
        exp = v.start + 32'(l * int'(v.pitch) + c);
        chk("R4 walk address", cur_addr, exp);
        for (int g = 0; g < int'(v.gap); g++) begin
          tick();
          chk("R3 no handshake hold", cur_addr, exp);
        end
        xfer_ack = 1'b1;
        tick();
        xfer_ack = 1'b0;
        last = (l == int'(v.lines)) && (c == int'(v.len) - 1);
        chk("R5 done pulse", 32'(irq_done), 32'(last));
      end
    end
    chk("R5 idle after last", 32'(busy), 32'd0);
    chk("R5 final address", cur_addr,
        v.start + 32'(int'(v.lines) * int'(v.pitch) + int'(v.len)));
    tick();
    chk("R10 done one cycle", 32'(irq_done), 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset addr", cur_addr, 32'd0);
    chk("R1 reset irq", 32'({irq_done, irq_half, irq_lap}), 32'd0);
    rst_n = 1'b1;
    tick();

    // table walk; loop_en low shows normal mode ignores it (R8)
    loop_en = 1'b0;
    foreach (VECS[i]) run_vec(VECS[i]);

    // handshake while idle is ignored (R3)
    xfer_ack = 1'b1;
    tick(); tick(); tick();
    xfer_ack = 1'b0;
    chk("R3 idle ack ignored", cur_addr, 32'h0000_0045);
    chk("R3 idle stays idle", 32'(busy), 32'd0);

    // ring mode: pitch 2, 4 lines -> 8 words, half at 4 (R6, R7)
    loop_en = 1'b1;
    cfg_len = '0; cfg_pitch = 16'd2; cfg_lines = 16'd3; cfg_ctrl = '0;
    addr_wdata = 32'h0000_0500; addr_wr = 1'b1;
    tick();
    addr_wr = 1'b0;
    chk("R6 ring start", cur_addr, 32'h0000_0500);
    xfer_ack = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      tick();
      chk("R6 ring address", cur_addr, 32'h0000_0500 + 32'(k % 8));
      chk("R7 half pulse", 32'(irq_half), 32'(k % 8 == 4));
      chk("R7 lap pulse", 32'(irq_lap), 32'(k % 8 == 0));
      chk("R6 ring stays busy", 32'(busy), 32'd1);
    end
    // pause and resume (R8)
    loop_en = 1'b0;
    tick(); tick(); tick();
    chk("R8 paused hold", cur_addr, 32'h0000_0502);
    loop_en = 1'b1;
    tick();
    xfer_ack = 1'b0;
    chk("R8 resumed step", cur_addr, 32'h0000_0503);
    // stop in ring mode (R9)
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk("R9 ring stop idle", 32'(busy), 32'd0);
    chk("R9 ring stop addr", cur_addr, 32'h0000_0503);

    // stop mid normal transfer, with handshake in same cycle (R9)
    cfg_len = 16'd4; cfg_pitch = 16'd16; cfg_lines = 16'd2;
    addr_wdata = 32'h0000_0900; addr_wr = 1'b1;
    tick();
    addr_wr = 1'b0;
    xfer_ack = 1'b1;
    tick(); tick();
    chk("R4 two words", cur_addr, 32'h0000_0902);
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk("R9 stop idle", 32'(busy), 32'd0);
    chk("R9 stop beats ack", cur_addr, 32'h0000_0902);
    chk("R9 stop no irq", 32'({irq_done, irq_half, irq_lap}), 32'd0);
    tick(); tick();
    xfer_ack = 1'b0;
    chk("R3 ack after stop ignored", cur_addr, 32'h0000_0902);

    // start beats stop (R9)
    addr_wdata = 32'h0000_0077; addr_wr = 1'b1; stop = 1'b1;
    tick();
    addr_wr = 1'b0; stop = 1'b0;
    chk("R9 start over stop busy", 32'(busy), 32'd1);
    chk("R9 start over stop addr", cur_addr, 32'h0000_0077);
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk("R9 final stop", 32'(busy), 32'd0);

    summary();
    $finish;
  end
endmodule